// File: doc/BRIEF.md
# Two-Way Set-Associative Next-Fetch-Address Predictor

This block sits beside the fetch stage of an in-order pipeline and guesses the address of the next instruction to fetch. Each cycle the fetch logic presents the current fetch address. In the same cycle, from combinational logic, the block returns a predicted next address. It also returns the way that was looked up, and the pipeline carries that way along with the instruction. The table has 64 entries, arranged as 32 sets of two ways. Each entry holds a full-address tag, a target address and a valid bit. Each set holds one least-recently-used bit.

When the real next address is known further down the pipeline, a training request comes back. It carries the instruction's own address, the recorded way, a flag that says whether the prediction was right, and the real target. Training reuses the recorded way and does not look the table up a second time. The entry is rewritten only when the prediction was wrong. A lookup and a training request may be issued in the same cycle, and they do not interfere with each other.

Top module: `nfa_pred2w`

## Requirements
- R1: The set index is bits [6:2] of the address (the address shifted right by two and truncated to 5 bits), which gives 32 sets of 2 ways, and each set is independent of the others.
- R2: A lookup hits only when a valid entry in the selected set holds a tag equal to the whole lookup address. On a hit, `look_hit` is 1 and `look_next` is the stored target.
- R3: On a miss, `look_hit` is 0 and `look_next` is the lookup address plus 4.
- R4: `look_way` is the hitting way on a hit. On a miss it is the first invalid way of the set (way 0 before way 1). When both ways are valid, it is the set's LRU way.
- R5: A training request with `train_ok`=1 leaves every entry unchanged.
- R6: A training request with `train_ok`=0 writes tag=`train_pc` and target=`train_target` into the set of `train_pc` at way `train_way`, and marks that entry valid from the next cycle on.
- R7: After reset no entry is valid, so every lookup misses.
- R8: An LRU update marks the way that was not touched as LRU. Both a lookup hit with `look_req`=1 and a training write cause an LRU update. When both update the same set in one cycle, the training write decides.
- R9: A lookup made in the same cycle as a training write to the same entry sees the old contents. The new contents are visible from the next cycle on.
- R10: Two addresses that map to one set can both hit, one in each way. A third address written to that set replaces only the way it was given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| look_req | input | 1 | A lookup is being issued; when 1, a hit updates the LRU bit |
| look_pc | input | 32 | Current fetch address |
| look_next | output | 32 | Predicted next fetch address |
| look_hit | output | 1 | Lookup hit a valid entry |
| look_way | output | 1 | Way to carry with the instruction for training |
| train_req | input | 1 | Training request valid |
| train_ok | input | 1 | The earlier prediction was correct |
| train_pc | input | 32 | Address of the trained instruction (tag and set source) |
| train_way | input | 1 | Way recorded at lookup time |
| train_target | input | 32 | Real next address |

## Verification
The hardest case to reach from the ports is a lookup hit and a training write that land on the same set in one cycle, because they ask for opposite LRU updates. The stimulus fills both ways of one set. It then issues a hitting lookup on way 0 in the same cycle as a mispredict write to way 1 of that set. Afterwards, a probe with a third, unmatched address in that set shows through `look_way` which update won. The same-cycle case with old contents is reached the same way, by driving a lookup and a write to the same entry in one cycle.

// File: rtl/nfa_pred2w_pkg.sv
// Shared constants and helper functions for the two-way next-address predictor.
// Assumes exactly two ways, so a way number and an LRU bit fit in one bit.
package nfa_pred2w_pkg;
    localparam int unsigned NUM_WAYS = 2;

    // Choose the way to report on a miss: an invalid way first, otherwise the LRU way.
    function automatic logic pick_victim(input logic vld0, input logic vld1, input logic lru);
        if (!vld0)      return 1'b0;
        else if (!vld1) return 1'b1;
        else            return lru;
    endfunction
endpackage

// File: rtl/nfa_way_store.sv
// One way of the table: valid bits, full-address tags and targets for every set.
// Assumes the read is combinational and the write takes effect at the clock edge,
// so a read in the same cycle as a write sees the old contents.
module nfa_way_store #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned SETS   = 32,
    localparam int unsigned IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [ADDR_W-1:0] rd_pc,
    output logic              rd_hit,
    output logic              rd_vld,
    output logic [ADDR_W-1:0] rd_target,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_tag,
    input  logic [ADDR_W-1:0] wr_target
);
    logic [SETS-1:0]   vld_q;
    logic [ADDR_W-1:0] tag_q [SETS];
    logic [ADDR_W-1:0] tgt_q [SETS];

    // Valid bits: cleared by reset, set by a training write.
    always_ff @(posedge clk) begin
        if (!rst_n)     vld_q <= '0;
        else if (wr_en) vld_q[wr_idx] <= 1'b1;
    end

    // Tag and target storage: written on a training write, not reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
        end
    end

    // Lookup: compare the full address with the stored tag.
    always_comb begin
        rd_vld    = vld_q[rd_idx];
        rd_hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_pc);
        rd_target = tgt_q[rd_idx];
    end

    // R6: a written entry is valid in the following cycle.
    p_write_sets_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_idx)]);

    // R5: without a write, the valid bits hold their value.
    p_no_write_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(vld_q));
endmodule

// File: rtl/nfa_lru_bits.sv
// One LRU bit per set; the bit names the way to replace next.
// Assumes two ways. When a hit and a write touch the same set in one cycle,
// the write is applied last and wins.
module nfa_lru_bits #(
    parameter int unsigned SETS   = 32,
    localparam int unsigned IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_lru,
    input  logic             hit_en,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic             hit_way,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_way
);
    logic [SETS-1:0] lru_q;

    // Update on hit, then on training write, so the write takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else begin
            if (hit_en) lru_q[hit_idx] <= ~hit_way;
            if (wr_en)  lru_q[wr_idx]  <= ~wr_way;
        end
    end

    // LRU read for the looked-up set.
    always_comb rd_lru = lru_q[rd_idx];

    // R8: a training write leaves the other way as LRU.
    p_write_sets_lru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (lru_q[$past(wr_idx)] == !$past(wr_way)));

    // R8: a hit with no write to that set leaves the other way as LRU.
    p_hit_sets_lru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_en && !(wr_en && wr_idx == hit_idx)) |=> (lru_q[$past(hit_idx)] == !$past(hit_way)));
endmodule

// File: rtl/nfa_pred2w.sv
// Two-way set-associative next-fetch-address predictor.
// The lookup is combinational from look_pc. Training uses the recorded way
// and the set index taken from train_pc, and writes only on a mispredict.
module nfa_pred2w #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned ROWS   = 64,
    localparam int unsigned WAYS  = nfa_pred2w_pkg::NUM_WAYS,
    localparam int unsigned SETS  = ROWS / WAYS,
    localparam int unsigned IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              look_req,
    input  logic [ADDR_W-1:0] look_pc,
    output logic [ADDR_W-1:0] look_next,
    output logic              look_hit,
    output logic              look_way,
    input  logic              train_req,
    input  logic              train_ok,
    input  logic [ADDR_W-1:0] train_pc,
    input  logic              train_way,
    input  logic [ADDR_W-1:0] train_target
);
    import nfa_pred2w_pkg::*;

    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic [WAYS-1:0]   way_hit, way_vld, way_we;
    logic [ADDR_W-1:0] way_tgt [WAYS];
    logic              set_lru, wr_en;

    // Set index: address shifted right by two, truncated to the index width.
    always_comb begin
        rd_idx = look_pc[IDX_W+1:2];
        wr_idx = train_pc[IDX_W+1:2];
        wr_en  = train_req && !train_ok;
    end

    // One storage instance per way, each written only when selected.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        always_comb way_we[w] = wr_en && (train_way == w[0]);

        nfa_way_store #(.ADDR_W(ADDR_W), .SETS(SETS)) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_idx    (rd_idx),
            .rd_pc     (look_pc),
            .rd_hit    (way_hit[w]),
            .rd_vld    (way_vld[w]),
            .rd_target (way_tgt[w]),
            .wr_en     (way_we[w]),
            .wr_idx    (wr_idx),
            .wr_tag    (train_pc),
            .wr_target (train_target)
        );
    end

    nfa_lru_bits #(.SETS(SETS)) u_lru (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .rd_lru  (set_lru),
        .hit_en  (look_req && look_hit),
        .hit_idx (rd_idx),
        .hit_way (look_way),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_way  (train_way)
    );

    // Prediction: stored target on a hit, sequential address on a miss.
    always_comb begin
        look_hit = |way_hit;
        if (way_hit[1])      look_way = 1'b1;
        else if (way_hit[0]) look_way = 1'b0;
        else                 look_way = pick_victim(way_vld[0], way_vld[1], set_lru);
        look_next = look_hit ? way_tgt[look_way] : look_pc + ADDR_W'(4);
    end

    // R2: a tag can match in at most one way of a set.
    p_single_way_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    // R7: nothing hits in the first cycle after reset.
    p_empty_after_reset_r7: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> !look_hit);

    // R4: a miss with a free way reports a free way.
    p_miss_prefers_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!look_hit && !(&way_vld)) |-> !way_vld[look_way]);
endmodule

// File: tb/nfa_pred2w_bench.sv
module nfa_pred2w_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        look_req = 1'b0;
    logic [31:0] look_pc = '0;
    logic [31:0] look_next;
    logic        look_hit;
    logic        look_way;
    logic        train_req = 1'b0;
    logic        train_ok = 1'b0;
    logic [31:0] train_pc = '0;
    logic        train_way = 1'b0;
    logic [31:0] train_target = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    nfa_pred2w u_nfa_pred2w (
        .clk(clk), .rst_n(rst_n), .look_req(look_req), .look_pc(look_pc),
        .look_next(look_next), .look_hit(look_hit), .look_way(look_way),
        .train_req(train_req), .train_ok(train_ok), .train_pc(train_pc),
        .train_way(train_way), .train_target(train_target)
    );

    // Probe: drive look_pc after a falling edge, compare just after.
    task automatic probe(input string req, input logic [31:0] pc, input logic req_en,
                         input logic e_hit, input logic [31:0] e_next, input logic e_way);
        @(negedge clk);
        look_pc  = pc;
        look_req = req_en;
        #1;
        n_chk++;
        if (look_hit !== e_hit || look_next !== e_next || look_way !== e_way) begin
            n_bad++;
            $display("FAIL %s pc=%h: got hit=%b next=%h way=%b, expected hit=%b next=%h way=%b",
                     req, pc, look_hit, look_next, look_way, e_hit, e_next, e_way);
        end
        @(posedge clk);
        #0.5;
        look_req = 1'b0;
    endtask

    task automatic train(input logic [31:0] pc, input logic way, input logic ok, input logic [31:0] tgt);
        @(negedge clk);
        train_req = 1'b1; train_pc = pc; train_way = way; train_ok = ok; train_target = tgt;
        @(negedge clk);
        train_req = 1'b0;
    endtask

    // R7, R3, R4: empty table after reset.
    task automatic t_reset_state();
        probe("R7", 32'h100, 1'b1, 1'b0, 32'h104, 1'b0);
        probe("R3", 32'h7C,  1'b0, 1'b0, 32'h80,  1'b0);
    endtask

    // R6, R2, R4, R5: write one entry, hit it, miss on a tag mismatch, ignore correct training.
    task automatic t_single_entry();
        train(32'h100, 1'b0, 1'b0, 32'h400);
        probe("R6", 32'h100, 1'b1, 1'b1, 32'h400, 1'b0);
        probe("R2", 32'h180, 1'b1, 1'b0, 32'h184, 1'b1);
        train(32'h100, 1'b0, 1'b1, 32'h999);
        probe("R5", 32'h100, 1'b1, 1'b1, 32'h400, 1'b0);
    endtask

    // R10, R8: both ways of set 0, LRU-driven victim, eviction of one way only.
    task automatic t_two_ways();
        train(32'h180, 1'b1, 1'b0, 32'h800);
        probe("R10", 32'h180, 1'b1, 1'b1, 32'h800, 1'b1);
        probe("R10", 32'h100, 1'b1, 1'b1, 32'h400, 1'b0);
        probe("R8",  32'h200, 1'b1, 1'b0, 32'h204, 1'b1);
        probe("R8",  32'h180, 1'b1, 1'b1, 32'h800, 1'b1);
        probe("R8",  32'h200, 1'b1, 1'b0, 32'h204, 1'b0);
        train(32'h200, 1'b0, 1'b0, 32'hA00);
        probe("R10", 32'h100, 1'b0, 1'b0, 32'h104, 1'b1);
        probe("R10", 32'h180, 1'b0, 1'b1, 32'h800, 1'b1);
        probe("R10", 32'h200, 1'b0, 1'b1, 32'hA00, 1'b0);
    endtask

    // R1: sets 31 and 30 are distinct.
    task automatic t_index_bits();
        train(32'h7C, 1'b0, 1'b0, 32'h40);
        probe("R1", 32'h7C, 1'b0, 1'b1, 32'h40, 1'b0);
        probe("R1", 32'h78, 1'b0, 1'b0, 32'h7C, 1'b0);
        probe("R1", 32'hFC, 1'b0, 1'b0, 32'h100, 1'b1);
    endtask

    // R9: a lookup in the cycle of the write sees the old contents.
    task automatic t_same_cycle();
        @(negedge clk);
        train_req = 1'b1; train_pc = 32'h14; train_way = 1'b0; train_ok = 1'b0; train_target = 32'h300;
        look_pc = 32'h14; look_req = 1'b1;
        #1;
        n_chk++;
        if (look_hit !== 1'b0 || look_next !== 32'h18) begin
            n_bad++;
            $display("FAIL R9: got hit=%b next=%h, expected hit=0 next=00000018", look_hit, look_next);
        end
        @(negedge clk);
        train_req = 1'b0; look_req = 1'b0;
        probe("R9", 32'h14, 1'b0, 1'b1, 32'h300, 1'b0);
    endtask

    // R8: a hit and a write to the same set in one cycle; the write decides LRU.
    task automatic t_lru_priority();
        @(negedge clk);
        look_pc = 32'h14; look_req = 1'b1;
        train_req = 1'b1; train_pc = 32'h94; train_way = 1'b1; train_ok = 1'b0; train_target = 32'h500;
        @(negedge clk);
        look_req = 1'b0; train_req = 1'b0;
        probe("R8", 32'h114, 1'b0, 1'b0, 32'h118, 1'b0);
        probe("R8", 32'h94,  1'b0, 1'b1, 32'h500, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_single_entry();
        t_two_ways();
        t_index_bits();
        t_same_cycle();
        t_lru_priority();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule